// File: doc/BRIEF.md
# Binary Field Multiply-Reduce Unit

This unit multiplies two elements of the binary field GF(2^m) held in polynomial basis. Bit i of an operand is the coefficient of x^i, and field addition is bitwise XOR. A start strobe captures both operands. A digit-serial carry-less multiplier then builds the full unreduced product of 2m-1 bits, taking D bits of the second operand in each cycle. After the last multiply cycle the product sits in a register. In the next cycle a bit-parallel fold network brings it back to m bits, using a five-term irreducible polynomial, and the reduced value is registered. Reduction therefore never shares a cycle with multiplication, and the critical path is the longer of the two steps rather than their sum.

Each completed result appears on two outputs. The result output holds its value until the next completion. The forward output carries the value only during the single cycle in which done is high and is zero at all other times. A neighbouring unit can therefore take the value as an operand in that same cycle without a write and read through a register file, and several such buses can be merged with plain OR or XOR. The field size, the digit width and the three middle exponents of the polynomial are parameters. The defaults give the 163-bit field with the polynomial x^163 + x^7 + x^6 + x^3 + 1.

Top module: `gfmr_unit`

## Requirements
- R1: While rst_ni is low, and until the internal reset synchronizer releases two clock edges after rst_ni rises, done_o, res_o and fwd_o are all zero. A reset that arrives during an operation abandons that operation, and no done pulse follows it.
- R2: The completed result equals opa·opb reduced modulo x^163 + x^7 + x^6 + x^3 + 1, with bit i the coefficient of x^i. This holds for zero, one, all-ones and pseudo-random operands, and for powers whose product needs two folding passes (x^162·x^162 = x^161 + x^12 + x^10 + x^5 + x).
- R3: done_o is high for exactly one cycle. It rises on the ceil(M/D)+1-th clock edge after the edge that accepts start_i: 22 edges with D = 8 and 2 edges with D = M.
- R4: res_o changes only on the edge that raises done_o. Between completions it keeps the last result, including during the whole of the following operation.
- R5: fwd_o equals res_o in the cycle where done_o is high and is zero in every other cycle.
- R6: A start_i pulse that arrives while an operation is in flight is ignored. The running operation completes with its own operands at its own time, and no extra done pulse follows.
- R7: Operands are sampled only on the accepting edge. Changes on opa_i and opb_i during the multiply and reduce cycles do not alter the result.
- R8: A start_i pulse in the cycle where done_o is high is accepted. Feeding fwd_o back as an operand in that cycle yields (a·b)·c with the normal latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begins an operation when the unit is idle or completing |
| opa_i | input | M | First operand, polynomial basis |
| opb_i | input | M | Second operand, consumed D bits per multiply cycle |
| done_o | output | 1 | One-cycle pulse when a reduced result is registered |
| res_o | output | M | Last reduced result, held until the next completion |
| fwd_o | output | M | Reduced result during the done cycle, zero otherwise |

## Verification
The bench builds two copies side by side from the same stimulus. One has D = 8: 163 is not a multiple of 8, so the last of its 21 multiply cycles uses a partly empty digit, and the 22-edge latency is exercised. The other has D = M, which forms the whole product in one multiply cycle and shows that the reduce step still takes a cycle of its own. Both copies use the default pentanomial, and operands that are high powers of x reach the second folding pass of the reduction network.

// File: rtl/gfmr_pkg.sv
package gfmr_pkg;

  // Count of middle terms in a five-term reduction polynomial.
  localparam int unsigned GFMR_NMID = 3;

  typedef enum logic [1:0] {
    GFMR_IDLE = 2'd0,
    GFMR_MUL  = 2'd1,
    GFMR_RED  = 2'd2
  } gfmr_state_e;

  function automatic int unsigned gfmr_cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/gfmr_rst_sync.sv
module gfmr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/gfmr_ctrl.sv
module gfmr_ctrl
  import gfmr_pkg::*;
#(
  parameter int unsigned NCYC = 21
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic mul_en_o,
  output logic red_en_o
);

  localparam int unsigned CW = (NCYC > 1) ? $clog2(NCYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(NCYC - 1);

  gfmr_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    load_o   = 1'b0;
    mul_en_o = 1'b0;
    red_en_o = 1'b0;
    case (state_q)
      GFMR_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          cnt_d   = '0;
          state_d = GFMR_MUL;
        end
      end
      GFMR_MUL: begin
        mul_en_o = 1'b1;
        if (cnt_q == LAST) begin
          state_d = GFMR_RED;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      GFMR_RED: begin
        red_en_o = 1'b1;
        state_d  = GFMR_IDLE;
      end
      default: begin
        state_d = GFMR_IDLE;
      end
    endcase
  end

  assign cnt_en = load_o | mul_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GFMR_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

endmodule

// File: rtl/gfmr_mac.sv
module gfmr_mac #(
  parameter int unsigned M = 163,
  parameter int unsigned D = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           mul_en_i,
  input  logic [M-1:0]   opa_i,
  input  logic [M-1:0]   opb_i,
  output logic [2*M-2:0] prod_o
);

  localparam int unsigned P = 2 * M - 1;

  logic [P-1:0] a_q, a_d;
  logic [P-1:0] acc_q, acc_d;
  logic [M-1:0] b_q, b_d;
  logic [P-1:0] pp [D];
  logic [P-1:0] part;
  logic         upd_en;

  // One shifted copy of the first operand per bit of the current digit.
  for (genvar j = 0; j < D; j++) begin : g_pp
    assign pp[j] = b_q[j] ? (a_q << j) : '0;
  end

  always_comb begin
    part = '0;
    for (int j = 0; j < D; j++) begin
      part = part ^ pp[j];
    end
  end

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    acc_d = acc_q;
    if (load_i) begin
      a_d   = {{(M-1){1'b0}}, opa_i};
      b_d   = opb_i;
      acc_d = '0;
    end else if (mul_en_i) begin
      acc_d = acc_q ^ part;
      a_d   = a_q << D;
      b_d   = b_q >> D;
    end
  end

  assign upd_en = load_i | mul_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
    end else if (upd_en) begin
      a_q   <= a_d;
      b_q   <= b_d;
      acc_q <= acc_d;
    end
  end

  assign prod_o = acc_q;

endmodule

// File: rtl/gfmr_fold.sv
module gfmr_fold
  import gfmr_pkg::*;
#(
  parameter int unsigned M = 163,
  parameter int unsigned MIDS [GFMR_NMID] = '{7, 6, 3}
) (
  input  logic [2*M-2:0] wide_i,
  output logic [M-1:0]   red_o
);

  // MIDS is listed largest first; two passes suffice while 2*MIDS[0] < M.
  localparam int unsigned P    = 2 * M - 1;
  localparam int unsigned KMAX = MIDS[0];
  localparam int unsigned T    = M + KMAX - 1;
  localparam int unsigned H1   = M - 1;
  localparam int unsigned H2   = KMAX - 1;

  logic [H1-1:0] hi1;
  logic [T-1:0]  hi1_x;
  logic [T-1:0]  sh1 [GFMR_NMID];
  logic [T-1:0]  pass1;
  logic [H2-1:0] hi2;
  logic [M-1:0]  hi2_x;
  logic [M-1:0]  sh2 [GFMR_NMID];

  // First pass: x^(M+i) becomes x^i times the low part of the polynomial.
  assign hi1   = wide_i[P-1:M];
  assign hi1_x = {{(T-H1){1'b0}}, hi1};

  for (genvar k = 0; k < GFMR_NMID; k++) begin : g_pass1
    assign sh1[k] = hi1_x << MIDS[k];
  end

  always_comb begin
    pass1 = {{(T-M){1'b0}}, wide_i[M-1:0]} ^ hi1_x;
    for (int k = 0; k < GFMR_NMID; k++) begin
      pass1 = pass1 ^ sh1[k];
    end
  end

  // Second pass: only the few bits pushed above M-1 by the largest term.
  assign hi2   = pass1[T-1:M];
  assign hi2_x = {{(M-H2){1'b0}}, hi2};

  for (genvar k = 0; k < GFMR_NMID; k++) begin : g_pass2
    assign sh2[k] = hi2_x << MIDS[k];
  end

  always_comb begin
    red_o = pass1[M-1:0] ^ hi2_x;
    for (int k = 0; k < GFMR_NMID; k++) begin
      red_o = red_o ^ sh2[k];
    end
  end

endmodule

// File: rtl/gfmr_unit.sv
module gfmr_unit
  import gfmr_pkg::*;
#(
  parameter int unsigned M = 163,
  parameter int unsigned D = 8,
  parameter int unsigned MIDS [GFMR_NMID] = '{7, 6, 3}
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [M-1:0] opa_i,
  input  logic [M-1:0] opb_i,
  output logic         done_o,
  output logic [M-1:0] res_o,
  output logic [M-1:0] fwd_o
);

  localparam int unsigned NCYC = gfmr_cdiv(M, D);
  localparam int unsigned P    = 2 * M - 1;

  logic         rst_sync_n;
  logic         load_w, mul_en_w, red_en_w;
  logic [P-1:0] prod_w;
  logic [M-1:0] red_w;

  logic [M-1:0] res_q, res_d;
  logic [M-1:0] fwd_q, fwd_d;
  logic         done_q, done_d;

  gfmr_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  gfmr_ctrl #(.NCYC(NCYC)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .start_i  (start_i),
    .load_o   (load_w),
    .mul_en_o (mul_en_w),
    .red_en_o (red_en_w)
  );

  gfmr_mac #(.M(M), .D(D)) u_mac (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .load_i   (load_w),
    .mul_en_i (mul_en_w),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .prod_o   (prod_w)
  );

  gfmr_fold #(.M(M), .MIDS(MIDS)) u_fold (
    .wide_i (prod_w),
    .red_o  (red_w)
  );

  // Reduction stage: its own register boundary after the product register.
  always_comb begin
    res_d  = red_en_w ? red_w : res_q;
    fwd_d  = red_en_w ? red_w : '0;
    done_d = red_en_w;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q  <= '0;
      fwd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      fwd_q  <= fwd_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign res_o  = res_q;
  assign fwd_o  = fwd_q;

endmodule

// File: rtl/gfmr_unit_chk.sv
module gfmr_unit_chk #(
  parameter int unsigned M    = 163,
  parameter int unsigned NCYC = 21
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         done_i,
  input logic [M-1:0] res_i,
  input logic [M-1:0] fwd_i
);

  localparam int unsigned LW = $clog2(NCYC + 3) + 1;

  // Cycles since the accepted start; zero when no operation is in flight.
  logic [LW-1:0] lat_q;
  logic          accept;

  assign accept = start_i && ((lat_q == '0) || done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
    end else if (accept) begin
      lat_q <= LW'(1);
    end else if (done_i) begin
      lat_q <= '0;
    end else if (lat_q != '0) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R3
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (lat_q == LW'(NCYC + 2)));

  // R4
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_i) |-> done_i);

  // R5
  fwd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> (fwd_i == '0));

  // R5
  fwd_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (fwd_i == res_i));

endmodule

bind gfmr_unit gfmr_unit_chk #(.M(M), .NCYC(NCYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_n),
  .start_i (start_i),
  .done_i  (done_o),
  .res_i   (res_o),
  .fwd_i   (fwd_o)
);

// File: tb/gfmr_unit_test.sv
module gfmr_unit_test;

  localparam int unsigned M  = 163;
  localparam int unsigned D  = 8;
  localparam int unsigned NA = (M + D - 1) / D;  // 21 multiply cycles
  localparam int unsigned NV = 8;

  localparam logic [M-1:0] ONE  = M'(1);
  localparam logic [M-1:0] ALL1 = {M{1'b1}};
  localparam logic [M-1:0] PAT  = M'({41{4'b1001}});
  localparam logic [M:0]   POLY = (165'(1) << 163) | 165'hC9;

  // Vector table: operand a, operand b, expected reduced product.
  localparam logic [M-1:0] TA [NV] = '{
    '0, ONE, ONE << 162, ONE << 162, ONE << 81, ONE << 100, ONE << 162, M'(3)};
  localparam logic [M-1:0] TB [NV] = '{
    ALL1, PAT, ONE << 1, ONE << 2, ONE << 81, ONE << 100, ONE << 162, ONE << 162};
  localparam logic [M-1:0] TE [NV] = '{
    '0, PAT, M'(8'hC9), M'(12'h192), ONE << 162,
    (ONE << 44) | (ONE << 43) | (ONE << 40) | (ONE << 37),
    (ONE << 161) | (ONE << 12) | (ONE << 10) | (ONE << 5) | (ONE << 1),
    (ONE << 162) | M'(8'hC9)};

  logic         clk;
  logic         rst_n;
  logic         start, start_w;
  logic [M-1:0] opa, opb;
  logic         done, done_w;
  logic [M-1:0] res, res_w, fwd, fwd_w;

  int errors = 0;
  int checks = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  gfmr_unit #(.M(M), .D(D)) uut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .opa_i (opa), .opb_i (opb),
    .done_o (done), .res_o (res), .fwd_o (fwd)
  );

  gfmr_unit #(.M(M), .D(M)) uut_w (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start_w),
    .opa_i (opa), .opb_i (opb),
    .done_o (done_w), .res_o (res_w), .fwd_o (fwd_w)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = {r[M-1:0], 1'b0};
      if (r[M]) r = r ^ POLY;
      if (b[i]) r[M-1:0] = r[M-1:0] ^ a;
    end
    return r[M-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic next_rand(output logic [M-1:0] v);
    logic [191:0] acc;
    for (int w = 0; w < 3; w++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 7);
      seed = seed ^ (seed << 17);
      acc[w*64 +: 64] = seed;
    end
    v = acc[M-1:0];
  endtask

  // Runs one operation on both units; operands are scrambled after acceptance.
  task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b,
                        output logic [M-1:0] r, output logic [M-1:0] rw);
    logic [M-1:0] prev, prevw;
    int n1, nw, at1, atw;
    n1 = 0; nw = 0; at1 = 0; atw = 0;
    r = '0; rw = '0;
    @(negedge clk);
    prev = res; prevw = res_w;
    opa = a; opb = b; start = 1'b1; start_w = 1'b1;
    @(negedge clk);
    start = 1'b0; start_w = 1'b0;
    opa = ~a; opb = ~b;  // R7: must not matter after the accepting edge
    for (int c = 1; c <= int'(NA) + 2; c++) begin
      @(negedge clk);
      if (done) begin
        n1++; at1 = c; r = res;
        chk(fwd == res, "R5 fwd in done cycle", fwd, res);
      end else begin
        chk(fwd == '0, "R5 fwd idle", fwd, '0);
        if (n1 == 0) chk(res == prev, "R4 res held", res, prev);
      end
      if (done_w) begin
        nw++; atw = c; rw = res_w;
        chk(fwd_w == res_w, "R5 wide fwd in done cycle", fwd_w, res_w);
      end else begin
        chk(fwd_w == '0, "R5 wide fwd idle", fwd_w, '0);
        if (nw == 0) chk(res_w == prevw, "R4 wide res held", res_w, prevw);
      end
    end
    chk(n1 == 1 && at1 == int'(NA) + 1, "R3 latency D=8", M'(at1), M'(NA + 1));
    chk(nw == 1 && atw == 2, "R3 latency D=M", M'(atw), M'(2));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [M-1:0] r, rw, a, b, c, e;
    int n, at;
    rst_n = 1'b0; start = 1'b0; start_w = 1'b0; opa = '0; opb = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!done && !done_w, "R1 done in reset", M'(done), '0);
    chk(res == '0 && fwd == '0, "R1 outputs in reset", res | fwd, '0);
    chk(res_w == '0 && fwd_w == '0, "R1 wide outputs in reset", res_w | fwd_w, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res == '0 && !done, "R1 during sync release", res, '0);
    repeat (3) @(negedge clk);

    // R2: table walk
    for (int i = 0; i < int'(NV); i++) begin
      run_op(TA[i], TB[i], r, rw);
      chk(r == TE[i], "R2 table D=8", r, TE[i]);
      chk(rw == TE[i], "R2 table D=M", rw, TE[i]);
    end

    // R2: corner operands and pseudo-random vectors against the reference
    run_op(ALL1, ALL1, r, rw);
    e = ref_mul(ALL1, ALL1);
    chk(r == e && rw == e, "R2 all-ones squared", r, e);
    next_rand(a);
    run_op(a, ONE, r, rw);
    chk(r == a && rw == a, "R2 a*1=a", r, a);
    run_op(ALL1, ONE, r, rw);
    chk(r == ALL1, "R2 all-ones*1", r, ALL1);
    run_op(ALL1, '0, r, rw);
    chk(r == '0 && rw == '0, "R2 x*0", r, '0);
    for (int i = 0; i < 6; i++) begin
      next_rand(a);
      next_rand(b);
      run_op(a, b, r, rw);
      e = ref_mul(a, b);
      chk(r == e, "R2 random D=8", r, e);
      chk(rw == e, "R2 random D=M", rw, e);
    end

    // R6: start while busy is ignored
    next_rand(a); next_rand(b); next_rand(c);
    e = ref_mul(a, b);
    n = 0; at = 0;
    @(negedge clk);
    opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 1; cyc <= 2 * int'(NA) + 4; cyc++) begin
      @(negedge clk);
      if (cyc == 5) begin opa = c; opb = c; start = 1'b1; end
      if (cyc == 6) start = 1'b0;
      if (done) begin n++; at = cyc; r = res; end
    end
    chk(n == 1 && at == int'(NA) + 1, "R6 single done", M'(at), M'(NA + 1));
    chk(r == e, "R6 result unaffected", r, e);

    // R7: operands change every cycle after acceptance
    next_rand(a); next_rand(b);
    e = ref_mul(a, b);
    @(negedge clk);
    opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 1; cyc <= int'(NA) + 1; cyc++) begin
      next_rand(c);
      opa = c; opb = ~c;
      @(negedge clk);
    end
    chk(done && res == e, "R7 late operand changes", res, e);

    // R8: back-to-back start using the forwarded result
    next_rand(a); next_rand(b); next_rand(c);
    e = ref_mul(ref_mul(a, b), c);
    @(negedge clk);
    opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (NA + 1) @(negedge clk);
    chk(done == 1'b1, "R8 first done", M'(done), M'(1));
    opa = fwd; opb = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (NA) @(negedge clk);
    chk(!done, "R8 chained not early", M'(done), '0);
    @(negedge clk);
    chk(done && res == e, "R8 chained result", res, e);

    // R1: reset during an operation abandons it
    next_rand(a);
    @(negedge clk);
    opa = a; opb = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(res == '0 && fwd == '0 && !done, "R1 mid-op reset", res, '0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    for (int cyc = 0; cyc < int'(NA) + 4; cyc++) begin
      @(negedge clk);
      if (done) n++;
    end
    chk(n == 0 && res == '0, "R1 no done after reset", res, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule